// File: doc/BRIEF.md
# Prioritized Interrupt Controller with DMA Steering

This block gathers event pulses from a set of peripheral sources and keeps one pending bit per source. For each source, software picks one of two destinations. The first is the processor, which receives a single request together with the level of the winning source and a vector number. The second is a DMA engine, which receives a request together with a channel number.

The processor side compares per-source 3-bit levels. Level 0 switches a source off. When two sources share a level, the lower source index wins. The DMA side ignores levels and serves the lowest pending index first. It does this through a two-state machine:

- **DM_IDLE**: waiting for work. It moves to DM_GRANT (transition "grant") when any DMA-steered request is pending.
- **DM_GRANT**: holds the chosen channel until the engine reports completion. It then returns to DM_IDLE (transition "complete").

On completion the controller drops the DMA request bit of the served channel and raises that source's cause flag. The processor can then be told that the transfer has finished.

Software reaches the state through a write port and a combinational read port. The write port clears flags, sets flags, writes both enable masks and writes the per-source levels. Both paths run at the same time and do not block each other.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset, all cause flags, DMA request bits, interrupt enables, DMA enables and levels read 0. irq_req, irq_lvl, irq_vec and dma_req are all 0.
- R2: An event pulse on a source whose DMA enable is 0 sets its cause flag. On a source whose DMA enable is 1 it sets the DMA request bit instead and leaves the cause flag unchanged.
- R3: A write to address 0 clears each flag whose data bit is 1. A write to address 1 sets each flag whose data bit is 1. An event arriving in the same cycle as a clear leaves that flag set.
- R4: A source takes part in processor arbitration only when its flag is 1, its interrupt enable is 1 and its level is not 0. irq_req is 1 exactly when such a source exists.
- R5: The processor winner is the taking-part source with the highest level. Among equal levels the lowest index wins, and irq_lvl carries the winner's level.
- R6: irq_vec equals VEC_BASE plus the winner's index. When irq_req is 0, both irq_lvl and irq_vec are 0.
- R7: The processor outputs are registered. They reflect the state left by a clock edge only at the following clock edge.
- R8: In DM_IDLE, a pending DMA request bit whose DMA enable is 1 moves the machine to DM_GRANT on the next edge. The lowest such index is taken as dma_ch, and dma_req stays 1 with dma_ch stable until completion.
- R9: A dma_done pulse in DM_GRANT clears that channel's DMA request bit, sets its cause flag and returns the machine to DM_IDLE. This keeps dma_req low for at least one cycle. A dma_done pulse in DM_IDLE changes nothing.
- R10: The register map is as follows. Read address 0 returns the flags and read address 1 returns the DMA request bits. Address 2 holds the interrupt enables and address 3 holds the DMA enables, and a write to either replaces the whole mask. Address 4+k holds the level of source k in data bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | N_SRC | One-cycle event pulse per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | N_SRC | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | N_SRC | Register read data (combinational) |
| dma_done | input | 1 | Completion pulse from the DMA engine |
| irq_req | output | 1 | Processor interrupt request |
| irq_lvl | output | PRIO_W | Level of the winning source |
| irq_vec | output | VEC_W | Vector number of the winning source |
| dma_req | output | 1 | DMA request |
| dma_ch | output | CH_W | Channel of the DMA request |

## Verification
A corrupted flag or level shows up at irq_req, irq_lvl and irq_vec at the clock edge after it occurs, because the arbiter output register sits one stage behind the flag storage. The level sweep would therefore miscompare within a single vector. A DMA machine stuck in DM_GRANT keeps dma_req high with no gap after a completion. A machine that latched the wrong channel produces a dma_ch that disagrees with the lowest pending index, and it leaves the wrong flag set after completion, which the read port shows one cycle later.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    typedef enum logic [0:0] {
        DM_IDLE  = 1'b0,
        DM_GRANT = 1'b1
    } dma_state_e;

    localparam int unsigned REG_FLAG_CLR  = 0;
    localparam int unsigned REG_FLAG_SET  = 1;
    localparam int unsigned REG_IRQ_EN    = 2;
    localparam int unsigned REG_DMA_EN    = 3;
    localparam int unsigned REG_PRIO_BASE = 4;

endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
    import irq_steer_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 3,
    parameter int AW     = 4,
    parameter int CH_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        src_evt,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [N_SRC-1:0]        wr_data,
    input  logic [AW-1:0]           rd_addr,
    input  logic                    done_hit,
    input  logic [CH_W-1:0]         done_ch,
    output logic [N_SRC-1:0]        flags,
    output logic [N_SRC-1:0]        dreq,
    output logic [N_SRC-1:0]        irq_en,
    output logic [N_SRC-1:0]        dma_en,
    output logic [N_SRC*PRIO_W-1:0] prio,
    output logic [N_SRC-1:0]        rd_data
);

    logic [N_SRC-1:0]        flag_q, flag_d;
    logic [N_SRC-1:0]        dreq_q, dreq_d;
    logic [N_SRC-1:0]        ien_q;
    logic [N_SRC-1:0]        den_q;
    logic [N_SRC*PRIO_W-1:0] prio_q;

    // Next-state of the pending bits: software clear, software set,
    // completion hand-back, then events last so they win every collision.
    always_comb begin
        flag_d = flag_q;
        dreq_d = dreq_q;
        if (wr_en && wr_addr == AW'(REG_FLAG_CLR)) begin
            flag_d = flag_d & ~wr_data;
        end
        if (wr_en && wr_addr == AW'(REG_FLAG_SET)) begin
            flag_d = flag_d | wr_data;
        end
        if (done_hit) begin
            dreq_d[done_ch] = 1'b0;
            flag_d[done_ch] = 1'b1;
        end
        flag_d = flag_d | (src_evt & ~den_q);
        dreq_d = dreq_d | (src_evt & den_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            dreq_q <= '0;
        end else begin
            flag_q <= flag_d;
            dreq_q <= dreq_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
            den_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(REG_IRQ_EN)) ien_q <= wr_data;
            if (wr_addr == AW'(REG_DMA_EN)) den_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < N_SRC; k++) begin
                if (wr_addr == AW'(REG_PRIO_BASE + k)) begin
                    prio_q[k*PRIO_W +: PRIO_W] <= wr_data[PRIO_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(REG_FLAG_CLR))      rd_data = flag_q;
        else if (rd_addr == AW'(REG_FLAG_SET)) rd_data = dreq_q;
        else if (rd_addr == AW'(REG_IRQ_EN))   rd_data = ien_q;
        else if (rd_addr == AW'(REG_DMA_EN))   rd_data = den_q;
        else begin
            for (int k = 0; k < N_SRC; k++) begin
                if (rd_addr == AW'(REG_PRIO_BASE + k)) begin
                    rd_data = N_SRC'(prio_q[k*PRIO_W +: PRIO_W]);
                end
            end
        end
    end

    assign flags  = flag_q;
    assign dreq   = dreq_q;
    assign irq_en = ien_q;
    assign dma_en = den_q;
    assign prio   = prio_q;

endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
    parameter int N_SRC    = 8,
    parameter int PRIO_W   = 3,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 32,
    parameter int CH_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        flags,
    input  logic [N_SRC-1:0]        irq_en,
    input  logic [N_SRC*PRIO_W-1:0] prio,
    output logic                    irq_req,
    output logic [PRIO_W-1:0]       irq_lvl,
    output logic [VEC_W-1:0]        irq_vec
);

    logic              hit;
    logic [PRIO_W-1:0] best_lvl;
    logic [CH_W-1:0]   best_idx;

    // Scan from the top index down; ">=" lets a lower index take over a tie.
    always_comb begin
        hit      = 1'b0;
        best_lvl = '0;
        best_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (flags[i] && irq_en[i] && prio[i*PRIO_W +: PRIO_W] != '0 &&
                prio[i*PRIO_W +: PRIO_W] >= best_lvl) begin
                hit      = 1'b1;
                best_lvl = prio[i*PRIO_W +: PRIO_W];
                best_idx = CH_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_lvl <= '0;
            irq_vec <= '0;
        end else begin
            irq_req <= hit;
            irq_lvl <= hit ? best_lvl : '0;
            irq_vec <= hit ? (VEC_W'(VEC_BASE) + VEC_W'(best_idx)) : '0;
        end
    end

endmodule

// File: rtl/irq_dma_fsm.sv
module irq_dma_fsm
    import irq_steer_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] dreq,
    input  logic [N_SRC-1:0] dma_en,
    input  logic             dma_done,
    output logic             dma_req,
    output logic [CH_W-1:0]  dma_ch,
    output logic             done_hit
);

    dma_state_e      state_q, state_d;
    logic            any_pend;
    logic [CH_W-1:0] pick;
    logic [CH_W-1:0] ch_q;

    // Fixed order, no levels: lowest pending index wins.
    always_comb begin
        any_pend = 1'b0;
        pick     = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (dreq[i] && dma_en[i]) begin
                any_pend = 1'b1;
                pick     = CH_W'(i);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DM_IDLE:  if (any_pend) state_d = DM_GRANT;
            DM_GRANT: if (dma_done) state_d = DM_IDLE;
            default:  state_d = DM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DM_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              ch_q <= '0;
        else if (state_q == DM_IDLE && any_pend) ch_q <= pick;
    end

    always_comb begin
        dma_req  = (state_q == DM_GRANT);
        done_hit = (state_q == DM_GRANT) && dma_done;
        dma_ch   = ch_q;
    end

endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl #(
    parameter int N_SRC    = 8,
    parameter int PRIO_W   = 3,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 32,
    parameter int AW       = $clog2(N_SRC + 4),
    parameter int CH_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_evt,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [N_SRC-1:0]  wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [N_SRC-1:0]  rd_data,
    input  logic              dma_done,
    output logic              irq_req,
    output logic [PRIO_W-1:0] irq_lvl,
    output logic [VEC_W-1:0]  irq_vec,
    output logic              dma_req,
    output logic [CH_W-1:0]   dma_ch
);

    logic [N_SRC-1:0]        flags_w;
    logic [N_SRC-1:0]        dreq_w;
    logic [N_SRC-1:0]        ien_w;
    logic [N_SRC-1:0]        den_w;
    logic [N_SRC*PRIO_W-1:0] prio_w;
    logic                    done_hit_w;

    irq_cause_bank #(
        .N_SRC(N_SRC), .PRIO_W(PRIO_W), .AW(AW), .CH_W(CH_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .done_hit(done_hit_w), .done_ch(dma_ch),
        .flags(flags_w), .dreq(dreq_w), .irq_en(ien_w), .dma_en(den_w),
        .prio(prio_w), .rd_data(rd_data)
    );

    irq_level_arb #(
        .N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W),
        .VEC_BASE(VEC_BASE), .CH_W(CH_W)
    ) u_larb (
        .clk(clk), .rst_n(rst_n), .flags(flags_w), .irq_en(ien_w),
        .prio(prio_w), .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_vec(irq_vec)
    );

    irq_dma_fsm #(
        .N_SRC(N_SRC), .CH_W(CH_W)
    ) u_dfsm (
        .clk(clk), .rst_n(rst_n), .dreq(dreq_w), .dma_en(den_w),
        .dma_done(dma_done), .dma_req(dma_req), .dma_ch(dma_ch),
        .done_hit(done_hit_w)
    );

endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
    parameter int N_SRC    = 8,
    parameter int PRIO_W   = 3,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 32,
    parameter int CH_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dma_done,
    input logic              irq_req,
    input logic [PRIO_W-1:0] irq_lvl,
    input logic [VEC_W-1:0]  irq_vec,
    input logic              dma_req,
    input logic [CH_W-1:0]   dma_ch,
    input logic [N_SRC-1:0]  flags,
    input logic [N_SRC-1:0]  dreq
);

    assert_lvl_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_lvl != '0);

    assert_vec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec >= VEC_W'(VEC_BASE) && irq_vec < VEC_W'(VEC_BASE + N_SRC)));

    assert_quiet_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_lvl == '0 && irq_vec == '0));

    assert_grant_backed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> dreq[dma_ch]);

    assert_ch_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_done) |=> (dma_req && $stable(dma_ch)));

    assert_done_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_done) |=> !dma_req);

    assert_done_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_done) |=> (flags[$past(dma_ch)] && !dreq[$past(dma_ch)]));

endmodule

bind irq_steer_ctrl irq_steer_chk #(
    .N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .CH_W(CH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dma_done(dma_done),
    .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_vec(irq_vec),
    .dma_req(dma_req), .dma_ch(dma_ch), .flags(flags_w), .dreq(dreq_w)
);

// File: tb/sim_irq_steer_ctrl.sv
`timescale 1ns/1ps
module sim_irq_steer_ctrl;

    localparam int N    = 8;
    localparam int PW   = 3;
    localparam int VW   = 8;
    localparam int VB   = 32;
    localparam int AW   = $clog2(N + 4);
    localparam int CW   = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_evt = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [N-1:0]  wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [N-1:0]  rd_data;
    logic          dma_done = 1'b0;
    logic          irq_req;
    logic [PW-1:0] irq_lvl;
    logic [VW-1:0] irq_vec;
    logic          dma_req;
    logic [CW-1:0] dma_ch;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_steer_ctrl #(.N_SRC(N), .PRIO_W(PW), .VEC_W(VW), .VEC_BASE(VB)) u0 (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .dma_done(dma_done), .irq_req(irq_req),
        .irq_lvl(irq_lvl), .irq_vec(irq_vec), .dma_req(dma_req), .dma_ch(dma_ch)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = N'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        rd_addr = AW'(a);
        #0.1;
        d = int'(rd_data);
    endtask

    task automatic pulse_evt(input int m);
        src_evt = N'(m);
        @(negedge clk);
        src_evt = '0;
    endtask

    task automatic pulse_done();
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
    endtask

    // Program one arbitration vector and compare after the output register.
    task automatic cpu_vec(input int pr[N], input int fl, input int en);
        int exp_lvl, exp_idx, v;
        for (int k = 0; k < N; k++) wr(4 + k, pr[k]);
        wr(2, en);
        wr(0, 'hFF);
        wr(1, fl);
        chk("R7 req before output stage", int'(irq_req), 0);
        rd(0, v);
        chk("R3 flags after set", v, fl);
        exp_lvl = 0; exp_idx = 0;
        for (int k = 0; k < N; k++) begin
            if (((fl >> k) & 1) == 1 && ((en >> k) & 1) == 1 && pr[k] > exp_lvl) begin
                exp_lvl = pr[k];
                exp_idx = k;
            end
        end
        tick();
        chk("R4 irq_req", int'(irq_req), (exp_lvl != 0) ? 1 : 0);
        chk("R5 irq_lvl", int'(irq_lvl), exp_lvl);
        chk("R6 irq_vec", int'(irq_vec), (exp_lvl != 0) ? VB + exp_idx : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        int pr[N];
        int seed;
        seed = 32'h1d2c3b4a;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 / R10: everything zero after reset
        chk("R1 irq_req", int'(irq_req), 0);
        chk("R1 irq_lvl", int'(irq_lvl), 0);
        chk("R1 irq_vec", int'(irq_vec), 0);
        chk("R1 dma_req", int'(dma_req), 0);
        for (int a = 0; a < N + 4; a++) begin
            rd(a, v);
            chk("R1 register zero", v, 0);
        end

        // R10: level register readback and width
        wr(4 + 3, 'hFD);
        rd(4 + 3, v);
        chk("R10 level field bits [2:0]", v, 5);
        wr(2, 'hA5);
        rd(2, v);
        chk("R10 irq enable mask", v, 'hA5);

        // R5: each source alone at every level, plus a tie against source 7
        for (int s = 0; s < N; s++) begin
            for (int l = 0; l < 8; l++) begin
                for (int k = 0; k < N; k++) pr[k] = 0;
                pr[s] = l;
                pr[N-1] = (s == N - 1) ? l : 3;
                cpu_vec(pr, (1 << s) | (1 << (N - 1)), 'hFF);
            end
        end

        // R4 R5 R6: pseudo-random sweep
        for (int t = 0; t < 160; t++) begin
            for (int k = 0; k < N; k++) begin
                seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
                pr[k] = (seed >> 4) & 7;
            end
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            cpu_vec(pr, seed & 'hFF, (seed >> 8) & 'hFF);
        end

        // R2: events without DMA steering set flags
        wr(2, 0);
        wr(0, 'hFF);
        wr(3, 0);
        pulse_evt('h3C);
        rd(0, v);
        chk("R2 event sets flags", v, 'h3C);
        rd(1, v);
        chk("R2 no DMA request bits", v, 0);

        // R3: event collides with clear
        wr(1, 'h03);
        wr_en = 1'b1; wr_addr = AW'(0); wr_data = N'('h03); src_evt = N'('h01);
        tick();
        wr_en = 1'b0; src_evt = '0;
        rd(0, v);
        chk("R3 event beats clear", v & 'h03, 'h01);

        // R2 R8: steered events become DMA requests
        wr(0, 'hFF);
        wr(3, 'hF0);
        pulse_evt('hFF);
        rd(0, v);
        chk("R2 flags only for unsteered", v, 'h0F);
        rd(1, v);
        chk("R2 DMA request bits", v, 'hF0);
        chk("R8 no grant yet", int'(dma_req), 0);
        tick();
        for (int c = 4; c < N; c++) begin
            chk("R8 dma_req asserted", int'(dma_req), 1);
            chk("R8 lowest channel", int'(dma_ch), c);
            repeat (3) tick();
            chk("R8 channel held", int'(dma_ch), c);
            pulse_done();
            chk("R9 gap after done", int'(dma_req), 0);
            rd(0, v);
            chk("R9 flag set by done", (v >> c) & 1, 1);
            rd(1, v);
            chk("R9 request bit cleared", (v >> c) & 1, 0);
            tick();
        end
        chk("R8 idle when drained", int'(dma_req), 0);

        // R9: completion while idle changes nothing
        pulse_done();
        rd(0, v);
        chk("R9 idle done flags", v, 'hFF);
        rd(1, v);
        chk("R9 idle done requests", v, 0);
        chk("R9 idle done no request", int'(dma_req), 0);

        // R9: completed channel reaches the processor
        wr(4 + 6, 5);
        wr(2, 'h40);
        wr(0, 'hBF);
        tick();
        chk("R9 irq after DMA done", int'(irq_req), 1);
        chk("R9 irq level", int'(irq_lvl), 5);
        chk("R9 irq vector", int'(irq_vec), VB + 6);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule